// File: doc/BRIEF.md
# Shared Signed/Unsigned Greater-Than Comparator

This block decides whether operand `a` is greater than operand `b`. Both operands are N bits wide. A mode input selects how the operands are read:

- as plain unsigned binary, or
- as two's-complement signed values.

The result is purely combinational. It is meant to sit inside a datapath that has to compare in both number systems without paying for two full comparators.

Only one magnitude comparator exists. It compares the N-1 low-order bits of the operands and is reused in both modes. A thin layer of logic on the two top bits then picks the answer:

- When the top bits are equal, the low-bit result stands in either mode. Two's-complement values with the same sign order the same way as their low bits do.
- When the top bits differ, the operand with the top bit set wins in unsigned mode.
- When the top bits differ, the operand with the top bit clear wins in signed mode.

Top module: `shared_cmp`

## Requirements
- R1: With `signed_mode`=0, `gt` is 1 exactly when `a` > `b` read as N-bit unsigned numbers.
- R2: With `signed_mode`=0 and differing top bits, `gt` equals the top bit of `a`.
- R3: With `signed_mode`=1 and differing sign bits (bit N-1), `gt` is 1 exactly when the sign bit of `a` is 0.
- R4: With `signed_mode`=1 and equal sign bits, `gt` equals the unsigned comparison of bits N-2..0. This holds for negative values too: at N=4, 4'b1111 > 4'b1100 > 4'b1001.
- R5: With `signed_mode`=1, `gt` is 1 exactly when `a` > `b` as N-bit two's-complement numbers.
- R6: When `a` equals `b`, `gt` is 0 in both modes.
- R7: With `signed_mode`=0 and equal top bits, `gt` equals the unsigned comparison of bits N-2..0.
- R8: `gt` follows a change of `a`, `b` or `signed_mode` with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | N | First operand |
| b | input | N | Second operand |
| signed_mode | input | 1 | 1: two's complement, 0: unsigned |
| gt | output | 1 | 1 when a is greater than b in the selected mode |

## Verification
The assertions are immediate checks that run whenever the inputs change. They assume `a`, `b` and `signed_mode` are all driven to known 0/1 values and are updated together. Under that assumption the shared low-bit result and the top-bit decision are settled at the point each check is evaluated. The bench keeps to this:

- It drives every input from a single task statement.
- It never leaves an input undriven.
- It waits a settling delay before sampling `gt`, away from the clock edge.

At the default N it sweeps every operand pair in both modes.

// File: rtl/shared_cmp_pkg.sv
package shared_cmp_pkg;
    typedef enum logic {
        MODE_UNSIGNED = 1'b0,
        MODE_TWOS     = 1'b1
    } cmp_mode_e;

    typedef struct packed {
        logic top_a;
        logic top_b;
        logic top_differ;
    } top_bits_t;
endpackage

// File: rtl/low_mag_cmp.sv
module low_mag_cmp #(
    parameter int W = 3
) (
    input  logic [W-1:0] lo_a,
    input  logic [W-1:0] lo_b,
    output logic         lo_gt
);
    logic gt_d;

    // Ripple from LSB upward: a higher differing bit overrides lower results.
    always_comb begin
        gt_d = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (lo_a[i] != lo_b[i]) begin
                gt_d = lo_a[i];
            end
        end
    end

    assign lo_gt = gt_d;

    // R4/R7 support: the ripple agrees with an unsigned reference
    always_comb begin
        a_r7_low_matches_ref: assert (lo_gt == (lo_a > lo_b))
            else $error("low compare disagrees with reference");
    end
endmodule

// File: rtl/top_bit_decide.sv
module top_bit_decide
    import shared_cmp_pkg::*;
(
    input  top_bits_t top,
    input  cmp_mode_e mode,
    input  logic      lo_gt,
    output logic      gt
);
    logic gt_d;

    always_comb begin
        if (top.top_differ) begin
            // unsigned: set top bit wins; two's complement: clear sign wins
            gt_d = (mode == MODE_TWOS) ? top.top_b : top.top_a;
        end else begin
            gt_d = lo_gt;
        end
    end

    assign gt = gt_d;
endmodule

// File: rtl/shared_cmp.sv
module shared_cmp
    import shared_cmp_pkg::*;
#(
    parameter int N = 4
) (
    input  logic [N-1:0] a,
    input  logic [N-1:0] b,
    input  logic         signed_mode,
    output logic         gt
);
    localparam int LW = N - 1;

    logic      lo_gt;
    top_bits_t top_d;
    cmp_mode_e mode_d;

    always_comb begin
        top_d.top_a      = a[N-1];
        top_d.top_b      = b[N-1];
        top_d.top_differ = a[N-1] ^ b[N-1];
        mode_d           = cmp_mode_e'(signed_mode);
    end

    low_mag_cmp #(.W(LW)) u_low (
        .lo_a  (a[LW-1:0]),
        .lo_b  (b[LW-1:0]),
        .lo_gt (lo_gt)
    );

    top_bit_decide u_top (
        .top   (top_d),
        .mode  (mode_d),
        .lo_gt (lo_gt),
        .gt    (gt)
    );

    always_comb begin
        if (!signed_mode) begin
            a_r1_unsigned_gt: assert (gt == (a > b))
                else $error("unsigned result wrong");
        end else begin
            a_r5_signed_gt: assert (gt == ($signed(a) > $signed(b)))
                else $error("signed result wrong");
        end
        if (signed_mode && (a[N-1] != b[N-1])) begin
            a_r3_sign_differs: assert (gt == ~a[N-1])
                else $error("sign-differs result wrong");
        end
        if (a[N-1] == b[N-1]) begin
            a_r4_same_top_uses_low: assert (gt == lo_gt)
                else $error("same-top result not from low compare");
        end
        if (a == b) begin
            a_r6_equal_not_gt: assert (!gt)
                else $error("equal operands reported greater");
        end
    end
endmodule

// File: tb/shared_cmp_tb.sv
module shared_cmp_tb_top;
    localparam int N = 4;
    localparam int V = 1 << N;

    logic         clk = 1'b0;
    logic [N-1:0] a = '0;
    logic [N-1:0] b = '0;
    logic         signed_mode = 1'b0;
    logic         gt;
    int           n_chk = 0;
    int           n_bad = 0;
    int           cycles = 0;
    logic         done = 1'b0;

    always #5 clk = ~clk;

    shared_cmp #(.N(N)) dut_i (
        .a(a), .b(b), .signed_mode(signed_mode), .gt(gt)
    );

    task automatic check(input string req, input logic exp);
        n_chk++;
        if (gt !== exp) begin
            n_bad++;
            $display("FAIL %s a=%b b=%b mode=%0d gt=%b expected=%b",
                     req, a, b, signed_mode, gt, exp);
        end
    endtask

    task automatic apply(input logic [N-1:0] av, input logic [N-1:0] bv, input logic m);
        @(negedge clk);
        a = av; b = bv; signed_mode = m;
        #1;
    endtask

    task automatic t_unsigned_sweep();
        for (int i = 0; i < V; i++)
            for (int j = 0; j < V; j++) begin
                apply(N'(i), N'(j), 1'b0);
                check("R1", i > j);
                if (a[N-1] != b[N-1]) check("R2", a[N-1]);
                else check("R7", a[N-2:0] > b[N-2:0]);
                if (i == j) check("R6", 1'b0);
            end
    endtask

    task automatic t_signed_sweep();
        for (int i = 0; i < V; i++)
            for (int j = 0; j < V; j++) begin
                apply(N'(i), N'(j), 1'b1);
                check("R5", $signed(a) > $signed(b));
                if (a[N-1] != b[N-1]) check("R3", !a[N-1]);
                else check("R4", a[N-2:0] > b[N-2:0]);
                if (i == j) check("R6", 1'b0);
            end
    endtask

    task automatic t_negative_order();
        apply(4'b1111, 4'b1100, 1'b1); check("R4", 1'b1);
        apply(4'b1100, 4'b1001, 1'b1); check("R4", 1'b1);
        apply(4'b1001, 4'b1111, 1'b1); check("R4", 1'b0);
        apply(4'b0000, 4'b1111, 1'b1); check("R3", 1'b1);
        apply(4'b0000, 4'b1111, 1'b0); check("R2", 1'b0);
    endtask

    task automatic t_no_clock_change();
        // change the mode between edges; gt must follow without any edge
        @(negedge clk);
        a = 4'b1000; b = 4'b0111; signed_mode = 1'b0;
        #1 check("R8", 1'b1);
        signed_mode = 1'b1;
        #1 check("R8", 1'b0);
        a = 4'b0111; b = 4'b1000;
        #1 check("R8", 1'b1);
    endtask

    initial begin
        apply('0, '0, 1'b0);
        check("R6", 1'b0);
        t_unsigned_sweep();
        t_signed_sweep();
        t_negative_order();
        t_no_clock_change();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles > 100000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule